// File: doc/BRIEF.md
# Programmable Baud Rate Generator Bank

This block holds eight independent clock divider channels. Each channel is steered by one 32-bit control word held in the block and written over a plain register port. The control word picks the channel's tick source, optionally inserts a divide-by-16 prescaler, and sets a main division count stored as divisor minus one. Separate bits restart the channel and gate its output. Every source is a one-cycle enable sampled in the single system clock, so the block contains no clock muxing across domains.

Each channel drives a square wave. Its period equals the total division measured in ticks of the selected source. The high phase comes first and, for an odd total, gets the extra tick. Software picks the prescaler only for totals above 4096. A new count written while a channel runs is held back until the current period finishes. The control words can be read back through a combinational read port.

Top module: `brg_bank`

## Requirements
- R1: Control word fields are: bit 0 selects the divide-by-16 prescaler, bits 12:1 hold the count N, bits 15:14 hold the source code, bit 16 is enable and bit 17 is channel reset. Reading a channel returns the last word written to it, with all 32 bits unchanged, in the cycle after the write.
- R2: The total division is N+1 source ticks with the prescaler off and 16*(N+1) ticks with it on. A total of 4096 is programmed without the prescaler; a total above it (for example 6000, programmed as N=374) uses it. The output period equals the total division.
- R3: The output is high for the first ceil(T/2) ticks of each period of T ticks and low for the rest. A total of one keeps the output high while the channel runs.
- R4: Source code 0 selects the internal tick input `int_tick`.
- R5: On channels 0, 1, 4 and 5, codes 1 and 2 select `ext_tick[0]` and `ext_tick[1]`. On channels 2, 3, 6 and 7, codes 1 and 2 select `ext_tick[2]` and `ext_tick[3]`.
- R6: Source code 3 selects no source. The channel's counters stay frozen and its output holds its level.
- R7: While the reset bit is set, the counters clear, the output is low and the written count is taken as the current divisor. After reset is cleared with enable set, the channel starts at the beginning of a high phase.
- R8: While the enable bit is clear, the output is low and the counters hold. Setting enable again resumes the period where it stopped.
- R9: A count written while the channel runs takes effect only after the current period's last tick. It does not shorten or lengthen that period.
- R10: After system reset, every control word reads as zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Write strobe for one control word |
| wr_addr | input | 3 | Channel index written |
| wr_data | input | 32 | Control word written |
| rd_addr | input | 3 | Channel index read |
| rd_data | output | 32 | Control word of the read channel (combinational) |
| int_tick | input | 1 | Internal generator tick enable |
| ext_tick | input | 4 | External tick enables, two per channel group |
| clk_out | output | 8 | Divided clock, one per channel |

## Verification
The bench targets the boundaries of the division arithmetic. The divide-by-one total must hold the output high, while a wrong phase split would toggle it or pull it low. Odd totals must give the extra tick to the high phase; an off-by-one split would shift every falling edge by one tick. The 4096 and 6000 totals cover both sides of the prescaler rule, where a composite-phase error would distort the long period. It also rewrites the count mid-period, where a design that loads at once would truncate or stretch the running period. It tests the group-dependent external mapping and the no-source code, which a shared mapping or a free-running counter would get wrong. Finally it stops and restarts channels, which exposes counters that fail to hold or restart from a stale phase.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Field widths of one control word
  localparam int unsigned BRG_CNT_W = 12;
  localparam int unsigned BRG_PRE_W = 4;
  localparam int unsigned BRG_TOT_W = BRG_CNT_W + BRG_PRE_W + 1;
  localparam int unsigned BRG_WORD_W = 32;

  // Field positions inside the control word
  localparam int unsigned F_DIV16  = 0;
  localparam int unsigned F_CNT_LO = 1;
  localparam int unsigned F_SRC_LO = 14;
  localparam int unsigned F_EN     = 16;
  localparam int unsigned F_RST    = 17;

  typedef enum logic [1:0] {
    SRC_INT   = 2'd0,
    SRC_EXT_A = 2'd1,
    SRC_EXT_B = 2'd2,
    SRC_NONE  = 2'd3
  } brg_src_e;

  typedef struct packed {
    logic                 rst;
    logic                 en;
    brg_src_e             src;
    logic                 div16;
    logic [BRG_CNT_W-1:0] cnt;
  } brg_ctl_t;

  // Total division in source ticks for a stored count and prescale flag
  function automatic logic [BRG_TOT_W-1:0] total_div(input logic [BRG_CNT_W-1:0] cnt,
                                                      input logic div16);
    logic [BRG_TOT_W-1:0] t;
    t = BRG_TOT_W'(cnt) + BRG_TOT_W'(1);
    if (div16) t = t << BRG_PRE_W;
    return t;
  endfunction

  // Ticks spent high in one period: the odd tick goes to the high phase
  function automatic logic [BRG_TOT_W-1:0] high_len(input logic [BRG_TOT_W-1:0] total);
    logic [BRG_TOT_W-1:0] t1;
    t1 = total + BRG_TOT_W'(1);
    return t1 >> 1;
  endfunction
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale
  import brg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ch_rst,
  input  logic                 adv,
  input  logic                 bypass,
  output logic [BRG_PRE_W-1:0] pre_cnt,
  output logic                 pre_tick
);
  assign pre_tick = adv && (bypass || (pre_cnt == {BRG_PRE_W{1'b1}}));

  always_ff @(posedge clk) begin
    if (!rst_n)               pre_cnt <= '0;
    else if (ch_rst)          pre_cnt <= '0;
    else if (adv && !bypass)  pre_cnt <= pre_cnt + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rst |=> (pre_cnt == '0)); // R7
endmodule

// File: rtl/brg_divider.sv
module brg_divider
  import brg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ch_rst,
  input  logic                 step,
  input  logic [BRG_CNT_W-1:0] load_val,
  output logic [BRG_CNT_W-1:0] ph_q,
  output logic [BRG_CNT_W-1:0] cur_q,
  output logic                 wrap
);
  assign wrap = step && (ph_q == cur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cur_q <= '0;
    end else if (ch_rst) begin
      ph_q  <= '0;
      cur_q <= load_val;
    end else if (wrap) begin
      ph_q  <= '0;
      cur_q <= load_val;
    end else if (step) begin
      ph_q  <= ph_q + 1'b1;
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= cur_q); // R2

  AST_COUNT_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_rst && !wrap) |=> $stable(cur_q)); // R9
endmodule

// File: rtl/brg_channel.sv
module brg_channel
  import brg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  brg_ctl_t ctl,
  input  logic     int_tick,
  input  logic [1:0] ext_pair,
  output logic     clk_out
);
  logic                 src_tick;
  logic                 run;
  logic                 adv;
  logic                 pre_tick;
  logic [BRG_PRE_W-1:0] pre_cnt;
  logic [BRG_CNT_W-1:0] ph_q;
  logic [BRG_CNT_W-1:0] cur_q;
  logic                 wrap;
  logic [BRG_TOT_W-1:0] phase;
  logic [BRG_TOT_W-1:0] hi_ticks;

  always_comb begin
    case (ctl.src)
      SRC_INT:   src_tick = int_tick;
      SRC_EXT_A: src_tick = ext_pair[0];
      SRC_EXT_B: src_tick = ext_pair[1];
      default:   src_tick = 1'b0;
    endcase
  end

  assign run = ctl.en && !ctl.rst;
  assign adv = run && src_tick;

  brg_prescale i_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_rst   (ctl.rst),
    .adv      (adv),
    .bypass   (!ctl.div16),
    .pre_cnt  (pre_cnt),
    .pre_tick (pre_tick)
  );

  brg_divider i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_rst   (ctl.rst),
    .step     (pre_tick),
    .load_val (ctl.cnt),
    .ph_q     (ph_q),
    .cur_q    (cur_q),
    .wrap     (wrap)
  );

  // Position inside the period, counted in source ticks
  assign phase    = ctl.div16 ? BRG_TOT_W'({ph_q, pre_cnt}) : BRG_TOT_W'(ph_q);
  assign hi_ticks = high_len(total_div(cur_q, ctl.div16));
  assign clk_out  = run && (phase < hi_ticks);

  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ctl.rst) |=> ($stable(ph_q) && $stable(pre_cnt))); // R6

  AST_WRAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !ctl.rst) |=> (ph_q == '0)); // R2
endmodule

// File: rtl/brg_bank.sv
module brg_bank
  import brg_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BRG_WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [BRG_WORD_W-1:0] rd_data,
  input  logic                  int_tick,
  input  logic [3:0]            ext_tick,
  output logic [NUM_CH-1:0]     clk_out
);
  logic [BRG_WORD_W-1:0] ctl_q [NUM_CH];
  brg_ctl_t              ctl_s [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) ctl_q[i] <= '0;
    end else if (wr_en) begin
      ctl_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = ctl_q[rd_addr];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // Channels pair up by index bit 1: that bit picks the external tick pair
    localparam int unsigned GRP = (g >> 1) & 1;

    assign ctl_s[g].rst   = ctl_q[g][F_RST];
    assign ctl_s[g].en    = ctl_q[g][F_EN];
    assign ctl_s[g].src   = brg_src_e'(ctl_q[g][F_SRC_LO +: 2]);
    assign ctl_s[g].div16 = ctl_q[g][F_DIV16];
    assign ctl_s[g].cnt   = ctl_q[g][F_CNT_LO +: BRG_CNT_W];

    brg_channel i_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl_s[g]),
      .int_tick (int_tick),
      .ext_pair (ext_tick[2*GRP +: 2]),
      .clk_out  (clk_out[g])
    );
  end

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q[$past(wr_addr)] == $past(wr_data))); // R1
endmodule

// File: tb/test_brg_bank.sv
`timescale 1ns/1ps
module test_brg_bank;
  localparam int NCH = 8;
  localparam time TCLK = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        int_tick = 1'b0;
  logic [3:0]  ext_tick = '0;
  logic [7:0]  clk_out;

  brg_bank i_brg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .int_tick(int_tick), .ext_tick(ext_tick),
    .clk_out(clk_out)
  );

  always #(TCLK/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Reference model state
  logic [31:0] mctl [NCH];
  int          pos  [NCH];
  int          curn [NCH];
  bit          vld  [NCH];
  string       tagv [NCH];

  bit          pw_en = 1'b0;
  logic [2:0]  pw_addr = '0;
  logic [31:0] pw_data = '0;
  bit          rb_pend = 1'b0;
  logic [31:0] rb_exp = '0;
  bit          force_it = 1'b0;

  function automatic logic [31:0] mk(bit rst, bit en, int src, bit d16, int n);
    return (32'(rst) << 17) | (32'(en) << 16) | (32'(src & 3) << 14) |
           (32'(n & 12'hfff) << 1) | 32'(d16);
  endfunction

  function automatic int mtot(int n, bit d16);
    return d16 ? (n + 1) * 16 : (n + 1);
  endfunction

  function automatic int mhigh(int t);
    return t - t / 2;
  endfunction

  function automatic bit msel(int c, int src, bit it, logic [3:0] et);
    int grp = (c / 2) % 2;
    case (src)
      0: return it;
      1: return et[grp * 2];
      2: return et[grp * 2 + 1];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    bit it;
    logic [3:0] et;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (vld[c]) begin
        bit e;
        e = !mctl[c][17] && mctl[c][16] &&
            (pos[c] < mhigh(mtot(curn[c], mctl[c][0])));
        chk(clk_out[c] == e, tagv[c], 32'(clk_out[c]), 32'(e));
      end
    end
    if (rb_pend) chk(rd_data == rb_exp, "R1", rd_data, rb_exp);
    rb_pend = 1'b0;
    it = force_it ? 1'b1 : 1'($urandom % 2);
    et = 4'($urandom % 16);
    for (int c = 0; c < NCH; c++) begin
      int n = int'(mctl[c][12:1]);
      bit d = mctl[c][0];
      if (mctl[c][17]) begin
        pos[c] = 0; curn[c] = n; vld[c] = 1'b1;
      end else if (mctl[c][16] && msel(c, int'(mctl[c][15:14]), it, et)) begin
        if (pos[c] == mtot(curn[c], d) - 1) begin
          pos[c] = 0; curn[c] = n;
        end else pos[c]++;
      end
    end
    if (pw_en) begin
      mctl[pw_addr] = pw_data;
      rb_pend = 1'b1;
      rb_exp = pw_data;
      rd_addr = pw_addr;
    end
    wr_en = pw_en; wr_addr = pw_addr; wr_data = pw_data;
    int_tick = it; ext_tick = et;
    pw_en = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    pw_en = 1'b1; pw_addr = 3'(a); pw_data = d;
    cycle();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic cfg(int c, int src, bit d16, int n, string tag);
    tagv[c] = tag;
    wr(c, mk(1, 0, src, d16, n));
    wr(c, mk(0, 1, src, d16, n));
  endtask

  // Software rule for splitting a total division into prescale and count
  task automatic cfg_total(int c, int total, string tag);
    if (total > 4096) cfg(c, 0, 1'b1, total / 16 - 1, tag);
    else              cfg(c, 0, 1'b0, total - 1, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0b2c));
    for (int c = 0; c < NCH; c++) begin
      mctl[c] = '0; pos[c] = 0; curn[c] = 0; vld[c] = 1'b1; tagv[c] = "R10";
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: words read as zero after system reset
    for (int a = 0; a < NCH; a++) begin
      rd_addr = 3'(a);
      #1;
      chk(rd_data == 32'h0, "R10", rd_data, 32'h0);
    end
    run(4);

    // Distinct sources, prescale and the divide-by-one case
    cfg(0, 0, 1'b0, 4, "R4");
    cfg(1, 1, 1'b0, 2, "R5");
    cfg(2, 1, 1'b0, 5, "R5");
    cfg(3, 2, 1'b0, 3, "R5");
    cfg(4, 2, 1'b0, 6, "R5");
    cfg(5, 0, 1'b1, 2, "R2");
    cfg(6, 3, 1'b0, 1, "R6");
    cfg(7, 0, 1'b0, 0, "R3");
    run(400);

    // R9: count changed while running
    tagv[0] = "R9"; tagv[1] = "R9";
    wr(0, mk(0, 1, 0, 1'b0, 9));
    wr(1, mk(0, 1, 1, 1'b0, 0));
    run(300);

    // R8: stop and resume
    tagv[2] = "R8";
    wr(2, mk(0, 0, 1, 1'b0, 5));
    run(50);
    wr(2, mk(0, 1, 1, 1'b0, 5));
    run(100);

    // R7: reset pulse in mid-period with a new count
    tagv[3] = "R7";
    wr(3, mk(1, 1, 2, 1'b0, 7));
    run(3);
    wr(3, mk(0, 1, 2, 1'b0, 7));
    run(150);

    // Random channel configurations, odd and even totals
    for (int r = 0; r < 24; r++) begin
      int c = int'($urandom % NCH);
      int src = int'($urandom % 4);
      bit d16 = ($urandom % 4) == 0;
      int n = int'($urandom % 24);
      cfg(c, src, d16, n, src == 3 ? "R6" : (src == 0 ? "R3" : "R5"));
      run(120);
    end

    // R1: arbitrary words read back unchanged
    for (int c = 0; c < NCH; c++) begin
      vld[c] = 1'b0;
      wr(c, 32'($urandom));
    end
    run(2);
    for (int c = 0; c < NCH; c++) wr(c, mk(1, 0, 0, 1'b0, 0));
    run(2);

    // R2: both sides of the prescale threshold, internal tick always on
    force_it = 1'b1;
    cfg_total(0, 6000, "R2");
    cfg_total(1, 4096, "R2");
    cfg_total(2, 7, "R3");
    run(12100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule